// File: doc/BRIEF.md
# Serial Flash Boot Loader with Golden-Image Fallback

This block pulls a configuration image out of an external serial flash, acting as the SPI master. When it receives a start pulse, it lowers chip select and sends a plain read command followed by a 24-bit start address. It then clocks in a fixed number of rows. Each row holds `ROW_BYTES` data bytes and ends with a 16-bit check value. The block computes the check value for each row as the row arrives and compares it with the stored one. Only a row that matches is passed to the configuration sink, as a one-cycle valid strobe with the whole row on a parallel bus.

When a row fails its check, that row is dropped. The block releases chip select and pulses an erase request so the sink discards what it has taken so far. It then makes exactly one more attempt, this time from the golden image at flash address zero. A clean load ends with a done flag that stays high until the next start. A golden image that also fails raises an error flag. That flag stays set until reset, and the block then ignores further starts.

The SPI clock is the system clock divided by `2*HALF_DIV`. With a 100 MHz system clock, the default gives roughly 2.08 MHz.

Top module: `spi_boot_loader`

## Requirements
- R1: After reset, chip select is high, the SPI clock is low, and row valid, erase request, done and error are all low.
- R2: A start pulse in the idle or done state begins a load. Chip select goes low and the block sends 0x03 and then the 24-bit address, MSB first, in SPI mode 0. SCK idles low, MOSI is stable at each rising SCK edge, and MISO is sampled on the rising edge.
- R3: While a byte is shifting, every high phase of SCK lasts exactly `HALF_DIV` system clocks and no low phase is shorter. SCK is low whenever chip select is high.
- R4: The first attempt of every load reads from the parameter `PRIMARY_ADDR`.
- R5: The flash data is read as `ROW_COUNT` rows back to back. Each row is `ROW_BYTES` data bytes followed by a check value, high byte first. The check value is CRC-16 with polynomial 0x1021 and seed 0xFFFF, computed MSB first, with no reflection and no final XOR.
- R6: A row whose check value matches is presented with a one-cycle row-valid pulse. The first byte read sits in the top 8 bits of the row bus.
- R7: A row whose check value does not match is never presented. Instead, chip select is released and the erase request pulses for one cycle.
- R8: After a failure on the primary image, the block raises chip select for a gap and then makes exactly one new read from address 0x000000. The golden rows are presented again starting from row 0.
- R9: Done rises once the last row has been presented, with chip select high. It stays high until the next start.
- R10: A failure during the golden attempt sets error, which stays set until reset. Done stays low, and start pulses are ignored.
- R11: A start pulse while a load is running has no effect. No new read is issued, and the row count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a load |
| spi_sck_o | output | 1 | SPI clock, idles low |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| row_valid_o | output | 1 | One-cycle strobe for a verified row |
| row_data_o | output | 8*ROW_BYTES | Verified row, first byte in the top bits |
| row_erase_o | output | 1 | One-cycle request to discard loaded rows |
| done_o | output | 1 | Load finished cleanly |
| error_o | output | 1 | Both primary and golden loads failed |

## Verification
The bench places a corrupted check value at a random row of the primary image. This shows whether rows before the fault still pass while the bad row is withheld. A design that forwards data before checking it, or that restarts the golden image at the failed row instead of row 0, produces a row list that does not match. A second case corrupts both images. A design that retries forever, or that reports done after a golden failure, shows an extra read or a wrong flag. A start pulse sent in the middle of a load catches a loader that restarts, and a start pulse sent after the error catches one that clears the sticky state.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_HDR,
    ST_BODY,
    ST_CHECK,
    ST_GAP,
    ST_DONE,
    ST_FAIL
  } load_state_t;

  localparam logic [7:0]  READ_CMD  = 8'h03;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [23:0] GOLD_ADDR = 24'h000000;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  data);
    logic [15:0] c;
    c = crc_in ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

  logic          busy;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sr;

  assign mosi_o = tx_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_o    <= '0;
      sck_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (go_i) begin
          busy    <= 1'b1;
          tx_sr   <= tx_i;
          bit_cnt <= '0;
          div_cnt <= '0;
          sck_o   <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_o  <= {rx_o[6:0], miso_i};
        end else begin
          sck_o <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy   <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sr   <= {tx_sr[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R3: the clock never sits high outside a byte transfer
  a_r3_sck_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck_o);

  // R3: a finished byte always leaves SCK low
  a_r3_done_on_low: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !sck_o);

endmodule

// File: rtl/crc16_accum.sv
module crc16_accum (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import spi_boot_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      crc_o <= CRC_SEED;
    end else if (en_i) begin
      crc_o <= crc16_step(crc_o, byte_i);
    end
  end

  // R5: a clear always restarts the sum from the seed
  a_r5_crc_seed: assert property (@(posedge clk) disable iff (rst)
    $past(clear_i) |-> (crc_o == 16'hFFFF));

endmodule

// File: rtl/row_shift_buffer.sv
module row_shift_buffer #(
  parameter int ROW_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push_i,
  input  logic [7:0]             byte_i,
  output logic [ROW_BYTES*8-1:0] row_o
);
  logic [7:0] lane [ROW_BYTES];

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    logic [7:0] src;
    if (g == 0) begin : g_head
      assign src = byte_i;
    end else begin : g_tail
      assign src = lane[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        lane[g] <= '0;
      end else if (push_i) begin
        lane[g] <= src;
      end
    end
    assign row_o[g*8 +: 8] = lane[g];
  end

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int          HALF_DIV     = 24,
  parameter int          ROW_BYTES    = 4,
  parameter int          ROW_COUNT    = 4,
  parameter logic [23:0] PRIMARY_ADDR = 24'h010000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  output logic                   spi_sck_o,
  output logic                   spi_cs_n_o,
  output logic                   spi_mosi_o,
  input  logic                   spi_miso_i,
  output logic                   row_valid_o,
  output logic [ROW_BYTES*8-1:0] row_data_o,
  output logic                   row_erase_o,
  output logic                   done_o,
  output logic                   error_o
);
  import spi_boot_pkg::*;

  localparam int ROW_W    = ROW_BYTES * 8;
  localparam int BCW      = $clog2(ROW_BYTES + 2);
  localparam int RCW      = (ROW_COUNT > 1) ? $clog2(ROW_COUNT) : 1;
  localparam int GAP      = 2 * HALF_DIV;
  localparam int GCW      = $clog2(GAP + 1);
  localparam logic [BCW-1:0] CRC_HI_IDX = BCW'(ROW_BYTES);
  localparam logic [BCW-1:0] CRC_LO_IDX = BCW'(ROW_BYTES + 1);
  localparam logic [RCW-1:0] LAST_ROW   = RCW'(ROW_COUNT - 1);
  localparam logic [GCW-1:0] GAP_LAST   = GCW'(GAP - 1);

  load_state_t    state;
  logic [23:0]    load_addr;
  logic [31:0]    hdr_sr;
  logic [1:0]     hdr_cnt;
  logic [BCW-1:0] byte_idx;
  logic [RCW-1:0] row_idx;
  logic [GCW-1:0] gap_cnt;
  logic [15:0]    crc_rx;
  logic           fallback_r;
  logic           go_r;
  logic [7:0]     tx_r;
  logic           crc_clr;

  logic           eng_done;
  logic [7:0]     eng_rx;
  logic [15:0]    crc_val;
  logic [ROW_W-1:0] row_buf;
  logic           data_push;

  assign data_push = eng_done && (state == ST_BODY) && (byte_idx < CRC_HI_IDX);

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go_r),
    .tx_i   (tx_r),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  crc16_accum u_crc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (crc_clr),
    .en_i    (data_push),
    .byte_i  (eng_rx),
    .crc_o   (crc_val)
  );

  row_shift_buffer #(.ROW_BYTES(ROW_BYTES)) u_row (
    .clk    (clk),
    .rst    (rst),
    .push_i (data_push),
    .byte_i (eng_rx),
    .row_o  (row_buf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      load_addr   <= PRIMARY_ADDR;
      hdr_sr      <= '0;
      hdr_cnt     <= '0;
      byte_idx    <= '0;
      row_idx     <= '0;
      gap_cnt     <= '0;
      crc_rx      <= '0;
      fallback_r  <= 1'b0;
      go_r        <= 1'b0;
      tx_r        <= '0;
      crc_clr     <= 1'b0;
      spi_cs_n_o  <= 1'b1;
      row_valid_o <= 1'b0;
      row_data_o  <= '0;
      row_erase_o <= 1'b0;
      done_o      <= 1'b0;
      error_o     <= 1'b0;
    end else begin
      go_r        <= 1'b0;
      crc_clr     <= 1'b0;
      row_valid_o <= 1'b0;
      row_erase_o <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            done_o     <= 1'b0;
            fallback_r <= 1'b0;
            load_addr  <= PRIMARY_ADDR;
            state      <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          spi_cs_n_o <= 1'b0;
          tx_r       <= READ_CMD;
          go_r       <= 1'b1;
          hdr_sr     <= {load_addr, 8'h00};
          hdr_cnt    <= '0;
          state      <= ST_HDR;
        end
        ST_HDR: begin
          if (eng_done) begin
            go_r <= 1'b1;
            if (hdr_cnt == 2'd3) begin
              tx_r     <= 8'h00;
              byte_idx <= '0;
              row_idx  <= '0;
              crc_clr  <= 1'b1;
              state    <= ST_BODY;
            end else begin
              tx_r    <= hdr_sr[31:24];
              hdr_sr  <= {hdr_sr[23:0], 8'h00};
              hdr_cnt <= hdr_cnt + 2'd1;
            end
          end
        end
        ST_BODY: begin
          if (eng_done) begin
            if (byte_idx == CRC_HI_IDX) begin
              crc_rx[15:8] <= eng_rx;
            end
            if (byte_idx == CRC_LO_IDX) begin
              crc_rx[7:0] <= eng_rx;
              state       <= ST_CHECK;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              tx_r     <= 8'h00;
              go_r     <= 1'b1;
            end
          end
        end
        ST_CHECK: begin
          if (crc_rx == crc_val) begin
            row_valid_o <= 1'b1;
            row_data_o  <= row_buf;
            if (row_idx == LAST_ROW) begin
              spi_cs_n_o <= 1'b1;
              done_o     <= 1'b1;
              state      <= ST_DONE;
            end else begin
              row_idx  <= row_idx + 1'b1;
              byte_idx <= '0;
              crc_clr  <= 1'b1;
              tx_r     <= 8'h00;
              go_r     <= 1'b1;
              state    <= ST_BODY;
            end
          end else begin
            spi_cs_n_o  <= 1'b1;
            row_erase_o <= 1'b1;
            if (!fallback_r) begin
              fallback_r <= 1'b1;
              load_addr  <= GOLD_ADDR;
              gap_cnt    <= '0;
              state      <= ST_GAP;
            end else begin
              error_o <= 1'b1;
              state   <= ST_FAIL;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            state <= ST_OPEN;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_FAIL: begin
          state <= ST_FAIL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: SCK only toggles with chip select asserted
  a_r3_sck_needs_cs: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n_o |-> !spi_sck_o);

  // R6: a verified row is announced for a single cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    row_valid_o |=> !row_valid_o);

  // R7: a discarded row is never announced alongside the erase request
  a_r7_valid_or_erase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({row_valid_o, row_erase_o}));

  // R9: completion implies the flash has been released
  a_r9_done_cs_high: assert property (@(posedge clk) disable iff (rst)
    done_o |-> spi_cs_n_o);

  // R10: error is sticky
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (rst)
    error_o |=> error_o);

  // R10: done and error never coexist
  a_r10_not_both: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));

endmodule

// File: tb/tb_spi_boot_loader.sv
`timescale 1ns/1ps
module tb_spi_boot_loader;
  localparam int HALF  = 3;
  localparam int RB    = 4;
  localparam int RC    = 4;
  localparam int STRIDE = RB + 2;
  localparam logic [23:0] PRIM = 24'h010000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sck, cs_n, mosi;
  logic miso = 1'b0;
  logic rv, erase, done, error;
  logic [RB*8-1:0] rdata;

  always #2.5 clk = ~clk;

  spi_boot_loader #(.HALF_DIV(HALF), .ROW_BYTES(RB), .ROW_COUNT(RC), .PRIMARY_ADDR(PRIM)) dut (
    .clk(clk), .rst(rst), .start_i(start),
    .spi_sck_o(sck), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .row_valid_o(rv), .row_data_o(rdata), .row_erase_o(erase),
    .done_o(done), .error_o(error)
  );

  // behavioural flash: primary at index 256.., golden at 0..
  logic [7:0]  mem [0:511];
  int          bitcnt = 0;
  int          opens  = 0;
  logic [31:0] hdr = '0;
  logic [23:0] rd_addr = '0;
  logic [7:0]  cmd_log  [0:15];
  logic [23:0] addr_log [0:15];

  function automatic int idx_of(input logic [23:0] a);
    return a[16] ? 256 + int'(a[7:0]) : int'(a[7:0]);
  endfunction

  always @(negedge cs_n) opens++;

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      bitcnt = 0;
    end else begin
      if (bitcnt < 32) hdr = {hdr[30:0], mosi};
      bitcnt++;
      if (bitcnt == 32) begin
        rd_addr = hdr[23:0];
        if (opens >= 1 && opens <= 16) begin
          cmd_log[opens-1]  = hdr[31:24];
          addr_log[opens-1] = hdr[23:0];
        end
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n && bitcnt >= 32) begin
      int k;
      logic [7:0] b;
      k = bitcnt - 32;
      b = mem[idx_of(rd_addr + 24'(k / 8))];
      miso = b[7 - (k % 8)];
    end
  end

  // output monitor
  logic [RB*8-1:0] got [0:127];
  int rcnt = 0, ecnt = 0, hi_cnt = 0, hi_bad = 0, hi_phases = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rv) begin
        if (rcnt < 128) got[rcnt] = rdata;
        rcnt++;
      end
      if (erase) ecnt++;
      if (sck) hi_cnt++;
      else if (hi_cnt > 0) begin
        if (hi_cnt != HALF) hi_bad++;
        hi_phases++;
        hi_cnt = 0;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [RB*8-1:0] exp_rows [0:15];
  int exp_n;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int base);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < RB; i++) begin
      c ^= {mem[base + i], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [RB*8-1:0] row_val(input int base);
    logic [RB*8-1:0] v = '0;
    for (int i = 0; i < RB; i++) v = {v[RB*8-9:0], mem[base + i]};
    return v;
  endfunction

  task automatic fill(input int base, input int bad_row);
    for (int r = 0; r < RC; r++) begin
      logic [15:0] c;
      for (int b = 0; b < RB; b++) mem[base + r*STRIDE + b] = 8'($urandom);
      c = ref_crc(base + r*STRIDE);
      if (r == bad_row) c ^= 16'h0100 | 16'($urandom_range(1, 255));
      mem[base + r*STRIDE + RB]     = c[15:8];
      mem[base + r*STRIDE + RB + 1] = c[7:0];
    end
  endtask

  task automatic add_exp(input int base, input int nrows);
    for (int r = 0; r < nrows; r++) begin
      exp_rows[exp_n] = row_val(base + r*STRIDE);
      exp_n++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_rows(input int base_cnt, input string req);
    check(rcnt - base_cnt == exp_n, req, rcnt - base_cnt, exp_n);
    for (int i = 0; i < exp_n && i < rcnt - base_cnt; i++)
      check(got[base_cnt + i] == exp_rows[i], req, got[base_cnt + i], exp_rows[i]);
  endtask

  bit finished = 0;

  initial begin
    int rb, eb, ob, bad;
    void'($urandom(32'd5150));
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 1 && sck == 0, "R1 spi idle", {cs_n, sck}, 2'b10);
    check({rv, erase, done, error} == 4'b0, "R1 flags", {rv, erase, done, error}, 0);

    // good primary load, with a stray start mid-load (R11)
    fill(256, -1); fill(0, -1);
    exp_n = 0; add_exp(256, RC);
    rb = rcnt; eb = ecnt; ob = opens;
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_end();
    check(opens - ob == 1, "R11 single read", opens - ob, 1);
    cmp_rows(rb, "R6 R5 primary rows");
    check(cmd_log[ob] == 8'h03, "R2 read command", cmd_log[ob], 8'h03);
    check(addr_log[ob] == PRIM, "R4 primary address", addr_log[ob], PRIM);
    check(done && !error && cs_n, "R9 done state", {done, error, cs_n}, 3'b101);
    check(ecnt == eb, "R7 no erase on clean load", ecnt - eb, 0);

    // random clean reloads from the done state (R9 restart)
    for (int t = 0; t < 3; t++) begin
      fill(256, -1);
      exp_n = 0; add_exp(256, RC);
      rb = rcnt; ob = opens;
      pulse_start();
      check(!done, "R9 done cleared by start", done, 0);
      wait_end();
      cmp_rows(rb, "R6 random reload rows");
      check(addr_log[ob] == PRIM, "R4 reload address", addr_log[ob], PRIM);
    end

    // primary fails at a random row, golden clean (R7, R8)
    bad = $urandom_range(1, RC - 1);
    fill(256, bad); fill(0, -1);
    exp_n = 0; add_exp(256, bad); add_exp(0, RC);
    rb = rcnt; eb = ecnt; ob = opens;
    pulse_start();
    wait_end();
    cmp_rows(rb, "R7 R8 fallback rows");
    check(ecnt - eb == 1, "R7 one erase pulse", ecnt - eb, 1);
    check(opens - ob == 2, "R8 exactly one retry", opens - ob, 2);
    check(addr_log[ob + 1] == 24'h0, "R8 golden address", addr_log[ob + 1], 0);
    check(cmd_log[ob + 1] == 8'h03, "R2 golden command", cmd_log[ob + 1], 8'h03);
    check(done && !error, "R9 done after fallback", {done, error}, 2'b10);

    // both images bad (R10)
    fill(256, 0); fill(0, 2);
    exp_n = 0; add_exp(0, 2);
    rb = rcnt; eb = ecnt; ob = opens;
    pulse_start();
    wait_end();
    cmp_rows(rb, "R10 golden rows before fault");
    check(error && !done, "R10 error flag", {error, done}, 2'b10);
    check(ecnt - eb == 2, "R10 erase count", ecnt - eb, 2);
    check(opens - ob == 2, "R10 no third read", opens - ob, 2);
    ob = opens; rb = rcnt;
    pulse_start();
    repeat (400) @(negedge clk);
    check(opens == ob && rcnt == rb, "R10 start ignored", opens - ob, 0);
    check(error && !done && cs_n, "R10 error sticky", {error, done, cs_n}, 3'b101);

    // SCK phase timing (R3)
    check(hi_bad == 0 && hi_phases > 0, "R3 high phase width", hi_bad, 0);

    // reset clears the error (R1)
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({cs_n, sck, done, error, rv, erase} == 6'b100000, "R1 after second reset",
          {cs_n, sck, done, error, rv, erase}, 6'b100000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule